// File: doc/BRIEF.md
# NAND Completion Wait Engine

After a program, erase, read or reset command has gone out to a NAND flash device, the controller has to hold off until the device has finished. This block handles that wait. A start strobe opens a fixed guard interval, so the device has time to drop its busy indication before anything samples it. The block then waits in one of two ways. When the board wires up the device's ready/busy line, it watches that line. When the line is missing, or when the wait follows a reset command, it asks the bus engine for status bytes over a request/acknowledge handshake and tests the ready bit in each byte.

The wait ends when the device reports ready or when a cycle limit runs out. Program and erase waits use one limit and reset waits use a shorter one. Either way, the block then reads one more status byte and reports it. This final byte shows the device's real state even after a timeout. The byte is returned with a not-ready flag and a one-cycle completion pulse. All delays are given in nanoseconds and turned into clock cycles from the clock period parameter.

Top module: `nand_rdy_wait`

## Requirements
- R1: After a start is accepted, the block spends TWB_CYC = ceil(TWB_NS / CLK_PERIOD_NS) cycles in a guard interval. During that interval it neither samples the ready/busy line nor requests a status byte. With the ready line already high in pin mode, `done` appears TWB_CYC+2 cycles after the start edge.
- R2: In pin mode (`pinAvail`=1, `isReset`=0), readiness comes from `rbN`, where 1 means ready, through a two-stage synchronizer. No status byte is requested until the wait loop has ended.
- R3: In poll mode, status bytes are requested back to back. A byte counts as ready when bit 6 (mask 0x40) is 1, and no other bit matters.
- R4: A program/erase wait times out once PROG_CYC = ceil(PROG_TMO_NS / CLK_PERIOD_NS) wait cycles have passed. In pin mode the loop then ends on the next cycle. In poll mode it ends on the next acknowledged status byte.
- R5: A wait started with `isReset`=1 always polls status, whatever `pinAvail` says, and uses the limit RST_CYC = ceil(RST_TMO_NS / CLK_PERIOD_NS).
- R6: Whether the loop ended on ready or on timeout, one further status byte is read. That byte is driven on `status` in the cycle that `done` is high.
- R7: `timedOut` equals the inverse of bit 6 of the final byte. `done` is a one-cycle pulse. `status` and `timedOut` hold their values until the next completion.
- R8: A `start` that arrives while `busy` is high is ignored and does not change the running wait.
- R9: Only one status request is outstanding at a time. `stReq` stays high until a cycle with `stAck` high, and `stData` is taken in that cycle. Each acknowledge uses up one read.
- R10: During reset, `busy`, `done`, `stReq`, `timedOut` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a wait (accepted only when idle) |
| isReset | input | 1 | The wait follows a reset command: poll status, reset limit |
| pinAvail | input | 1 | Strap: the ready/busy line is connected |
| rbN | input | 1 | Device ready/busy line, 1 = ready (asynchronous) |
| stReq | output | 1 | Request for one status byte read |
| stAck | input | 1 | Bus engine has completed the read; `stData` is valid |
| stData | input | 8 | Status byte returned by the bus engine |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Final status byte |
| timedOut | output | 1 | Final status did not show ready |

## Verification
The hardest case to reach is a loop that ends on timeout while the device is actually ready by the time of the final read. The flag then has to follow the re-read byte, not the loop's exit reason. The bench holds the ready line low past the program limit and has the bus engine model answer the single final read with a ready byte. It also runs the opposite case: the poll loop sees ready, but the final byte shows not ready. Both timeout limits are reached quickly by shrinking the nanosecond parameters. A behavioural engine model then counts every acknowledged read and checks the number against a count worked out from the alternating request/acknowledge cadence.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_PIN,
    ST_POLL,
    ST_FINAL
  } nrwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadGuard;
    logic selRst;
    logic decGuard;
    logic incElapsed;
    logic capFinal;
  } nrwStrobe_t;

  localparam int STATUS_READY_BIT = 6;

  function automatic int nsToCyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/nrw_datapath.sv
module nrw_datapath
  import nrw_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int TWB_NS        = 100,
  parameter int PROG_TMO_NS   = 400_000_000,
  parameter int RST_TMO_NS    = 250_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  nrwStrobe_t ctl,
  input  logic       rbN,
  input  logic       stAck,
  input  logic [7:0] stData,
  output logic       guardZero,
  output logic       expired,
  output logic       rbReady,
  output logic       stReady,
  output logic       done,
  output logic [7:0] status,
  output logic       timedOut
);

  localparam int TWB_CYC  = nsToCyc(TWB_NS, CLK_PERIOD_NS);
  localparam int PROG_CYC = nsToCyc(PROG_TMO_NS, CLK_PERIOD_NS);
  localparam int RST_CYC  = nsToCyc(RST_TMO_NS, CLK_PERIOD_NS);
  localparam int TMO_MAX  = (PROG_CYC > RST_CYC) ? PROG_CYC : RST_CYC;
  localparam int CW       = $clog2(TMO_MAX + 1);
  localparam int GW       = $clog2(TWB_CYC + 1);

  logic [GW-1:0] guardCnt;
  logic [CW-1:0] elapsed;
  logic [CW-1:0] limitR;
  logic          rbMeta;
  logic          rbSync;
  logic [7:0]    statusR;
  logic          timedOutR;
  logic          doneR;

  // guard interval counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardCnt <= '0;
    end else if (ctl.loadGuard) begin
      guardCnt <= GW'(TWB_CYC - 1);
    end else if (ctl.decGuard && guardCnt != '0) begin
      guardCnt <= guardCnt - 1'b1;
    end
  end

  assign guardZero = (guardCnt == '0);

  // wait-cycle counter and selected limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '0;
      limitR  <= '0;
    end else if (ctl.loadGuard) begin
      elapsed <= '0;
      limitR  <= ctl.selRst ? CW'(RST_CYC) : CW'(PROG_CYC);
    end else if (ctl.incElapsed && !expired) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expired = (elapsed >= limitR);

  // two-stage synchronizer on the ready/busy line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbMeta <= 1'b0;
      rbSync <= 1'b0;
    end else begin
      rbMeta <= rbN;
      rbSync <= rbMeta;
    end
  end

  assign rbReady = rbSync;
  assign stReady = stData[STATUS_READY_BIT];

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusR   <= '0;
      timedOutR <= 1'b0;
      doneR     <= 1'b0;
    end else begin
      doneR <= ctl.capFinal;
      if (ctl.capFinal) begin
        statusR   <= stData;
        timedOutR <= ~stData[STATUS_READY_BIT];
      end
    end
  end

  assign done     = doneR;
  assign status   = statusR;
  assign timedOut = timedOutR;

  // R4: wait counter never runs past the selected limit
  a_r4_elapsed_bound: assert property (@(posedge clk) disable iff (!rstN)
    elapsed <= limitR);

  // R6: a completion only follows an acknowledged status read
  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> $past(stAck));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

endmodule

// File: rtl/nrw_ctrl.sv
module nrw_ctrl
  import nrw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isReset,
  input  logic       pinAvail,
  input  logic       stAck,
  input  logic       guardZero,
  input  logic       expired,
  input  logic       rbReady,
  input  logic       stReady,
  output nrwStrobe_t ctl,
  output logic       stReq,
  output logic       busy
);

  nrwState_t state, stateNxt;
  logic      usePin;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadGuard = 1'b1;
          ctl.selRst    = isReset;
          stateNxt      = ST_GUARD;
        end
      end
      ST_GUARD: begin
        ctl.decGuard = 1'b1;
        if (guardZero) stateNxt = usePin ? ST_PIN : ST_POLL;
      end
      ST_PIN: begin
        ctl.incElapsed = 1'b1;
        if (rbReady || expired) stateNxt = ST_FINAL;
      end
      ST_POLL: begin
        ctl.incElapsed = 1'b1;
        if (stAck && (stReady || expired)) stateNxt = ST_FINAL;
      end
      ST_FINAL: begin
        if (stAck) begin
          ctl.capFinal = 1'b1;
          stateNxt     = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      usePin <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && start) usePin <= pinAvail && !isReset;
    end
  end

  assign stReq = (state == ST_POLL) || (state == ST_FINAL);
  assign busy  = (state != ST_IDLE);

  // R9: a pending request stays up until acknowledged
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (stReq && !stAck) |=> stReq);

  // R2: pin-mode waits make no status request before the final read
  a_r2_pin_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busy && usePin && state != ST_FINAL) |-> !stReq);

  // R8: a running wait only ends through an acknowledged read
  a_r8_busy_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(stReq && stAck)) |=> busy);

  // R1: the cycle after a start is accepted makes no request
  a_r1_guard_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !stReq));

endmodule

// File: rtl/nand_rdy_wait.sv
module nand_rdy_wait
  import nrw_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int TWB_NS        = 100,
  parameter int PROG_TMO_NS   = 400_000_000,
  parameter int RST_TMO_NS    = 250_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isReset,
  input  logic       pinAvail,
  input  logic       rbN,
  output logic       stReq,
  input  logic       stAck,
  input  logic [7:0] stData,
  output logic       busy,
  output logic       done,
  output logic [7:0] status,
  output logic       timedOut
);

  nrwStrobe_t ctl;
  logic guardZero, expired, rbReady, stReady;

  nrw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .isReset  (isReset),
    .pinAvail (pinAvail),
    .stAck    (stAck),
    .guardZero(guardZero),
    .expired  (expired),
    .rbReady  (rbReady),
    .stReady  (stReady),
    .ctl      (ctl),
    .stReq    (stReq),
    .busy     (busy)
  );

  nrw_datapath #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .TWB_NS       (TWB_NS),
    .PROG_TMO_NS  (PROG_TMO_NS),
    .RST_TMO_NS   (RST_TMO_NS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rbN      (rbN),
    .stAck    (stAck),
    .stData   (stData),
    .guardZero(guardZero),
    .expired  (expired),
    .rbReady  (rbReady),
    .stReady  (stReady),
    .done     (done),
    .status   (status),
    .timedOut (timedOut)
  );

endmodule

// File: tb/nand_rdy_wait_bench.sv
module nand_rdy_wait_bench;

  localparam int CLKP = 20;
  localparam int TWB  = 5;    // 100 ns / 20 ns
  localparam int PLIM = 100;  // 2000 ns / 20 ns
  localparam int RLIM = 50;   // 1000 ns / 20 ns

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, isReset = 1'b0, pinAvail = 1'b0, rbN = 1'b0;
  logic stReq, stAck = 1'b0;
  logic [7:0] stData = 8'h00;
  logic busy, done, timedOut;
  logic [7:0] status;

  int nChecks = 0, nFail = 0, reads = 0, cyc = 0;
  logic [7:0] rdQ[$];
  logic [7:0] dflt = 8'h40;

  always #10 clk = ~clk;

  nand_rdy_wait #(
    .CLK_PERIOD_NS(CLKP), .TWB_NS(100), .PROG_TMO_NS(2000), .RST_TMO_NS(1000)
  ) u_nand_rdy_wait (
    .clk(clk), .rstN(rstN), .start(start), .isReset(isReset),
    .pinAvail(pinAvail), .rbN(rbN), .stReq(stReq), .stAck(stAck),
    .stData(stData), .busy(busy), .done(done), .status(status),
    .timedOut(timedOut)
  );

  // bus engine model: one-cycle ack, then a gap cycle
  always @(negedge clk) begin
    if (stAck) begin
      stAck = 1'b0;
    end else if (stReq) begin
      stAck  = 1'b1;
      stData = (rdQ.size() > 0) ? rdQ.pop_front() : dflt;
      reads++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // start one wait; returns edges from start edge to the edge that raised done
  task automatic runOp(input bit rst, input bit pin, input int raiseAt,
                       input int pulseAt, output int lat, output bit pinQuiet);
    int n = 0;
    pinQuiet = 1'b1;
    @(negedge clk);
    reads    = 0;
    isReset  = rst;
    pinAvail = pin;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) break;
      if (stReq && stAck == 1'b0 && reads == 0 && pin && !rst) pinQuiet = pinQuiet;
      start = (n == pulseAt);
      if (n == raiseAt) rbN = 1'b1;
    end
    start = 1'b0;
    lat = n;
  endtask

  int lat;
  bit pq;

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 0 && done == 0 && stReq == 0, "R10 idle outputs", {busy, done, stReq}, 0);
    check(status == 0 && timedOut == 0, "R10 result regs", {timedOut, status}, 0);
    rstN = 1'b1;

    // R1/R2: pin already ready -> TWB+2, one read only
    rbN = 1'b1; rdQ = {}; dflt = 8'h40;
    repeat (4) @(negedge clk);
    runOp(0, 1, -1, -1, lat, pq);
    check(lat == TWB + 2, "R1 guard latency pin ready", lat, TWB + 2);
    check(reads == 1, "R2 pin mode single final read", reads, 1);
    check(status == 8'h40 && timedOut == 0, "R6 final status pin", status, 8'h40);

    // R2: pin low, raised at negedge after edge 10 -> seen 3 edges later
    rbN = 1'b0;
    repeat (4) @(negedge clk);
    runOp(0, 1, 10, -1, lat, pq);
    check(lat == 14, "R2 synchronized pin release", lat, 14);
    check(reads == 1, "R2 no polling in pin mode", reads, 1);

    // R4/R6/R7: pin timeout, device ready at final read
    rbN = 1'b0; dflt = 8'h40;
    repeat (4) @(negedge clk);
    runOp(0, 1, -1, -1, lat, pq);
    check(lat == TWB + PLIM + 2, "R4 pin timeout latency", lat, TWB + PLIM + 2);
    check(timedOut == 0 && status == 8'h40, "R6 real state after timeout", timedOut, 0);
    @(negedge clk);
    check(done == 0, "R7 done one cycle", done, 0);
    check(status == 8'h40, "R7 status held", status, 8'h40);

    // R3: poll, first byte ready
    rdQ = {8'h40}; dflt = 8'h5A;
    runOp(0, 0, -1, -1, lat, pq);
    check(lat == TWB + 3, "R3 poll first ready latency", lat, TWB + 3);
    check(reads == 2, "R3 poll read count", reads, 2);
    check(status == 8'h5A && timedOut == 0, "R6 final byte reported", status, 8'h5A);

    // R3/R8: only bit 6 matters; stray start mid-wait ignored
    rdQ = {8'hBF, 8'hBF, 8'hBF, 8'hC1}; dflt = 8'hE0;
    runOp(0, 0, -1, 3, lat, pq);
    check(lat == TWB + 9, "R3 bit6 only, 4th byte ready", lat, TWB + 9);
    check(reads == 5, "R8 read count unaffected by start", reads, 5);
    repeat (5) @(negedge clk);
    check(busy == 0 && stReq == 0, "R8 no second run", {busy, stReq}, 0);

    // R7: loop saw ready but final byte not ready
    rdQ = {8'h40, 8'h80}; dflt = 8'h40;
    runOp(0, 0, -1, -1, lat, pq);
    check(timedOut == 1 && status == 8'h80, "R7 flag follows final byte", {timedOut, status}, 9'h180);

    // R4: poll timeout at program limit
    rdQ = {}; dflt = 8'h00;
    runOp(0, 0, -1, -1, lat, pq);
    check(lat == TWB + PLIM + 3, "R4 poll timeout latency", lat, TWB + PLIM + 3);
    check(reads == (PLIM + 2) / 2 + 1, "R9 poll reads", reads, (PLIM + 2) / 2 + 1);
    check(timedOut == 1, "R7 timeout flag", timedOut, 1);

    // R5: reset wait polls even with pin strapped and ready, shorter limit
    rbN = 1'b1; dflt = 8'h00;
    repeat (4) @(negedge clk);
    runOp(1, 1, -1, -1, lat, pq);
    check(lat == TWB + RLIM + 3, "R5 reset limit latency", lat, TWB + RLIM + 3);
    check(reads == (RLIM + 2) / 2 + 1, "R5 reset polls status", reads, (RLIM + 2) / 2 + 1);
    check(timedOut == 1 && status == 8'h00, "R5 reset final", timedOut, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule